// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular receive area of a 32 KB packet RAM that is 16 bits wide. The area is given as a first and a last 256-byte page. Each frame takes an 8-byte header slot followed by its payload. The payload is rounded up to whole 16-bit words, so every frame starts on a word boundary.

The header holds four 16-bit words. Word 0 is the completion marker, word 1 is the reception status, word 2 is the byte address where the next frame will begin, and word 3 is the byte count. The block writes the marker twice. It clears the marker when a frame starts and sets it only after every other word of the frame is in RAM. Software that polls the marker therefore never sees a half-written frame.

Software frees space by moving a stop word address forward. The block never writes that word. If a frame would need it, the block drops the frame, leaves the write position where it was and signals an overflow.

Usage rules:
- The page limits change only while reset is held.
- A new frame must not begin until at least four idle cycles have passed after the byte that carried the end-of-frame flag.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the block issues no RAM write and holds `ovf` low until a frame arrives. The first frame's header is placed at byte address `lo_page`*256.
- R2: The first RAM write of an accepted frame stores 0x0000 at the header's word 0. This write comes before any payload write.
- R3: Payload bytes are packed in arrival order. The earlier byte of each pair goes in bits 7:0. Words are written at rising addresses, starting 8 bytes after the header. An odd final byte has 0x00 in bits 15:8.
- R4: After the last payload word, the header words are written in this order: status at header+2, next-frame pointer at header+4, byte count at header+6. The last write is 0x0008 to header+0.
- R5: The status word is 0x2000 when no byte of the frame had `rx_err` set. It is 0x0080 when any byte did.
- R6: Bits 13:0 of the byte count word hold the frame length in bytes. Bits 15:14 are zero.
- R7: The next-frame pointer is the byte address that follows the frame's last payload word. The next frame's header is placed at that address.
- R8: The word after byte address `hi_page`*256+0xFE is `lo_page`*256. This wrap applies to header words and payload words alike.
- R9: The word at `stop_word` is never written. A frame dropped at a header slot makes no write. A frame dropped at a payload word makes no further write. A dropped frame gives exactly one cycle of `ovf` and writes no status, pointer, count or 0x0008 marker. The next frame reuses the same header address.
- R10: Every RAM write falls inside the area from `lo_page`*256 to `hi_page`*256+0xFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_err | input | 1 | This byte was received with an error |
| lo_page | input | 7 | First 256-byte page of the receive area |
| hi_page | input | 7 | Last 256-byte page of the receive area |
| stop_word | input | 14 | Word address that software has not yet freed |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | 14 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| ovf | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
A wrong write pointer shows up at once as a wrong address on the header-clear write of the next frame. A wrong payload pointer shows up on the first payload write after the bad state appears. A stale length or error flag stays hidden until the header words are written, four to five cycles after the last byte. A wrong stop decision shows up either as a write to the protected word or as an `ovf` pulse in the same cycle the block should have written. The directed frames therefore place the header slot across the wrap point and put the stop word on a header slot, on a payload word, and just past the end of a frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int RXR_AW = 15;            // byte address width of packet RAM
  localparam int RXR_PW = RXR_AW - 8;    // page number width
  localparam int RXR_WW = 16;            // RAM word width

  typedef logic [RXR_AW-1:0] rptr_t;
  typedef logic [RXR_PW-1:0] pg_t;

  localparam logic [RXR_WW-1:0] EVT_NONE = 16'h0000;
  localparam logic [RXR_WW-1:0] EVT_DONE = 16'h0008;
  localparam logic [RXR_WW-1:0] STS_GOOD = 16'h2000;
  localparam logic [RXR_WW-1:0] STS_BAD  = 16'h0080;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_DROP, ST_HSTS, ST_HNXT, ST_HCNT, ST_HEVT
  } ctl_st_e;

  function automatic rptr_t pg_base(pg_t p);
    return {p, 8'h00};
  endfunction

  function automatic rptr_t pg_top(pg_t p);
    return {p, 8'hFE};
  endfunction

  // next word address inside the ring
  function automatic rptr_t ring_step(rptr_t p, rptr_t base, rptr_t top);
    return (p == top) ? base : p + rptr_t'(2);
  endfunction
endpackage

// File: rtl/rxr_byte_pack.sv
module rxr_byte_pack
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  output logic              start_o,
  output logic              wv_o,
  output logic [RXR_WW-1:0] wdata_o,
  output logic              wlast_o,
  output logic              wodd_o,
  output logic              werr_o
);
  logic       have_lo;
  logic [7:0] lo_byte;
  logic       flush;
  logic       err_acc;
  logic       in_frame;
  logic       err_next;

  always_comb err_next = err_acc | in_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_o  <= 1'b0;
      wv_o     <= 1'b0;
      wdata_o  <= '0;
      wlast_o  <= 1'b0;
      wodd_o   <= 1'b0;
      werr_o   <= 1'b0;
      have_lo  <= 1'b0;
      lo_byte  <= '0;
      flush    <= 1'b0;
      err_acc  <= 1'b0;
      in_frame <= 1'b0;
    end else begin
      start_o <= 1'b0;
      wv_o    <= 1'b0;
      wlast_o <= 1'b0;
      wodd_o  <= 1'b0;
      if (flush) begin
        // single-byte frame: its lone word leaves one cycle after the start
        wv_o    <= 1'b1;
        wdata_o <= {8'h00, lo_byte};
        wlast_o <= 1'b1;
        wodd_o  <= 1'b1;
        werr_o  <= err_acc;
        flush   <= 1'b0;
        have_lo <= 1'b0;
      end
      if (in_valid) begin
        if (in_sof) begin
          start_o  <= 1'b1;
          lo_byte  <= in_data;
          have_lo  <= 1'b1;
          err_acc  <= in_err;
          in_frame <= !in_eof;
          flush    <= in_eof;
        end else if (in_frame) begin
          if (have_lo) begin
            wv_o    <= 1'b1;
            wdata_o <= {in_data, lo_byte};
            wlast_o <= in_eof;
            werr_o  <= err_next;
            have_lo <= 1'b0;
          end else if (in_eof) begin
            wv_o    <= 1'b1;
            wdata_o <= {8'h00, in_data};
            wlast_o <= 1'b1;
            wodd_o  <= 1'b1;
            werr_o  <= err_next;
          end else begin
            lo_byte <= in_data;
            have_lo <= 1'b1;
          end
          err_acc <= err_next;
          if (in_eof) in_frame <= 1'b0;
        end
      end
    end
  end

  AST_START_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !wv_o); // R2
endmodule

// File: rtl/rxr_ring_ctl.sv
module rxr_ring_ctl
  import rxr_pkg::*;
#(
  parameter int LEN_W = 14
)(
  input  logic              clk,
  input  logic              rst_n,
  input  pg_t               lo_pg,
  input  pg_t               hi_pg,
  input  logic [RXR_AW-2:0] stop_word,
  input  logic              start,
  input  logic              wv,
  input  logic [RXR_WW-1:0] wdata,
  input  logic              wlast,
  input  logic              wodd,
  input  logic              werr,
  output logic              req_we,
  output logic [RXR_AW-2:0] req_word,
  output logic [RXR_WW-1:0] req_data,
  output logic              drop
);
  ctl_st_e    st;
  rptr_t      wptr, hdr, ptr;
  logic [LEN_W-1:0] len;
  logic       bad;

  rptr_t base, top;
  rptr_t s1, s2, s3, d0;
  rptr_t h1, h2, h3;
  logic  hdr_blk, ptr_blk;

  always_comb begin
    base = pg_base(lo_pg);
    top  = pg_top(hi_pg);
    s1 = ring_step(wptr, base, top);
    s2 = ring_step(s1, base, top);
    s3 = ring_step(s2, base, top);
    d0 = ring_step(s3, base, top);
    h1 = ring_step(hdr, base, top);
    h2 = ring_step(h1, base, top);
    h3 = ring_step(h2, base, top);
    hdr_blk = (wptr[RXR_AW-1:1] == stop_word) || (s1[RXR_AW-1:1] == stop_word) ||
              (s2[RXR_AW-1:1] == stop_word) || (s3[RXR_AW-1:1] == stop_word);
    ptr_blk = (ptr[RXR_AW-1:1] == stop_word);
  end

  always_comb begin
    req_we   = 1'b0;
    req_word = ptr[RXR_AW-1:1];
    req_data = wdata;
    drop     = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        if (hdr_blk) drop = 1'b1;
        else begin
          req_we   = 1'b1;
          req_word = wptr[RXR_AW-1:1];
          req_data = EVT_NONE;
        end
      end
      ST_RECV: if (wv) begin
        if (ptr_blk) drop = 1'b1;
        else req_we = 1'b1;
      end
      ST_HSTS: begin
        req_we   = 1'b1;
        req_word = h1[RXR_AW-1:1];
        req_data = bad ? STS_BAD : STS_GOOD;
      end
      ST_HNXT: begin
        req_we   = 1'b1;
        req_word = h2[RXR_AW-1:1];
        req_data = RXR_WW'(ptr);
      end
      ST_HCNT: begin
        req_we   = 1'b1;
        req_word = h3[RXR_AW-1:1];
        req_data = RXR_WW'(len);
      end
      ST_HEVT: begin
        req_we   = 1'b1;
        req_word = hdr[RXR_AW-1:1];
        req_data = EVT_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      wptr <= pg_base(lo_pg);
      hdr  <= '0;
      ptr  <= '0;
      len  <= '0;
      bad  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          if (hdr_blk) st <= ST_DROP;
          else begin
            hdr <= wptr;
            ptr <= d0;
            len <= '0;
            bad <= 1'b0;
            st  <= ST_RECV;
          end
        end
        ST_RECV: if (wv) begin
          if (ptr_blk) st <= wlast ? ST_IDLE : ST_DROP;
          else begin
            ptr <= ring_step(ptr, base, top);
            len <= len + (wodd ? LEN_W'(1) : LEN_W'(2));
            bad <= werr;
            if (wlast) st <= ST_HSTS;
          end
        end
        ST_DROP: if (wv && wlast) st <= ST_IDLE;
        ST_HSTS: st <= ST_HNXT;
        ST_HNXT: st <= ST_HCNT;
        ST_HCNT: st <= ST_HEVT;
        ST_HEVT: begin
          wptr <= ptr;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_NO_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_we |-> (req_word != stop_word)); // R9
  AST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    req_we |-> (req_word >= base[RXR_AW-1:1] && req_word <= top[RXR_AW-1:1])); // R10
  AST_WPTR_HOLD_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(wptr)); // R9
endmodule

// File: rtl/rxr_wr_port.sv
module rxr_wr_port
  import rxr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [RXR_AW-2:0] req_word,
  input  logic [RXR_WW-1:0] req_data,
  input  logic              drop,
  output logic              mem_we,
  output logic [RXR_AW-2:0] mem_addr,
  output logic [RXR_WW-1:0] mem_wdata,
  output logic              ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ovf       <= 1'b0;
    end else begin
      mem_we <= req_we;
      ovf    <= drop;
      if (req_we) begin
        mem_addr  <= req_word;
        mem_wdata <= req_data;
      end
    end
  end

  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf); // R9
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
  import rxr_pkg::*;
#(
  parameter int LEN_W = 14
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [RXR_PW-1:0] lo_page,
  input  logic [RXR_PW-1:0] hi_page,
  input  logic [RXR_AW-2:0] stop_word,
  output logic              mem_we,
  output logic [RXR_AW-2:0] mem_addr,
  output logic [RXR_WW-1:0] mem_wdata,
  output logic              ovf
);
  logic              pk_start, pk_wv, pk_wlast, pk_wodd, pk_werr;
  logic [RXR_WW-1:0] pk_wdata;
  logic              rq_we, rq_drop;
  logic [RXR_AW-2:0] rq_word;
  logic [RXR_WW-1:0] rq_data;

  rxr_byte_pack u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_data(rx_data), .in_sof(rx_sof),
    .in_eof(rx_eof), .in_err(rx_err),
    .start_o(pk_start), .wv_o(pk_wv), .wdata_o(pk_wdata),
    .wlast_o(pk_wlast), .wodd_o(pk_wodd), .werr_o(pk_werr)
  );

  rxr_ring_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .lo_pg(lo_page), .hi_pg(hi_page), .stop_word(stop_word),
    .start(pk_start), .wv(pk_wv), .wdata(pk_wdata),
    .wlast(pk_wlast), .wodd(pk_wodd), .werr(pk_werr),
    .req_we(rq_we), .req_word(rq_word), .req_data(rq_data), .drop(rq_drop)
  );

  rxr_wr_port u_port (
    .clk(clk), .rst_n(rst_n),
    .req_we(rq_we), .req_word(rq_word), .req_data(rq_data), .drop(rq_drop),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ovf(ovf)
  );
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [6:0]  lo_page = '0, hi_page = '0;
  logic [13:0] stop_word = '0;
  logic        mem_we, ovf;
  logic [13:0] mem_addr;
  logic [15:0] mem_wdata;

  always #2 clk = ~clk;

  rxr_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .lo_page(lo_page), .hi_page(hi_page), .stop_word(stop_word),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ovf(ovf)
  );

  int n_chk = 0, n_err = 0;
  int nlog = 0, ovf_cnt = 0, stop_hits = 0, out_region = 0;
  logic [13:0] log_a [0:511];
  logic [15:0] log_d [0:511];
  int m_hdr, m_base, m_top;
  int e_a [0:127];
  int e_d [0:127];
  int e_n;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (nlog < 512) begin log_a[nlog] = mem_addr; log_d[nlog] = mem_wdata; end
      nlog++;
      if (mem_addr == stop_word) stop_hits++;
      if (int'(mem_addr) * 2 < m_base || int'(mem_addr) * 2 > m_top) out_region++;
    end
    if (ovf) ovf_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nx(int p);
    return (p == m_top) ? m_base : p + 2;
  endfunction

  function automatic int byte_of(int seed, int i);
    return (seed + i * 37) & 8'hFF;
  endfunction

  task automatic do_reset(int lo, int hi, int stop);
    rst_n = 1'b0;
    lo_page = 7'(lo); hi_page = 7'(hi); stop_word = 14'(stop);
    m_base = lo * 256; m_top = hi * 256 + 'hFE; m_hdr = m_base;
    repeat (3) @(negedge clk);
    nlog = 0; ovf_cnt = 0;
    rst_n = 1'b1;
  endtask

  // sends a frame, compares all RAM writes and the ovf count with the model
  task automatic run_frame(int len, int seed, int err_pos, string tag);
    int start_log, start_ovf, p, exp_ovf, hdr0;
    bit blocked;
    int st = stop_word;
    e_n = 0; exp_ovf = 0; hdr0 = m_hdr;
    p = m_hdr; blocked = 0;
    for (int k = 0; k < 4; k++) begin
      if ((p >> 1) == st) blocked = 1;
      p = nx(p);
    end
    if (blocked) exp_ovf = 1;
    else begin
      e_a[e_n] = m_hdr >> 1; e_d[e_n] = 0; e_n++;
      for (int w = 0; w < (len + 1) / 2; w++) begin
        int hi;
        if ((p >> 1) == st) begin exp_ovf = 1; break; end
        hi = (2 * w + 1 < len) ? byte_of(seed, 2 * w + 1) : 0;
        e_a[e_n] = p >> 1; e_d[e_n] = (hi << 8) | byte_of(seed, 2 * w); e_n++;
        p = nx(p);
      end
      if (exp_ovf == 0) begin
        e_a[e_n] = nx(m_hdr) >> 1; e_d[e_n] = (err_pos >= 0) ? 'h0080 : 'h2000; e_n++;
        e_a[e_n] = nx(nx(m_hdr)) >> 1; e_d[e_n] = p; e_n++;
        e_a[e_n] = nx(nx(nx(m_hdr))) >> 1; e_d[e_n] = len & 'h3FFF; e_n++;
        e_a[e_n] = m_hdr >> 1; e_d[e_n] = 8; e_n++;
        m_hdr = p;
      end
    end
    start_log = nlog; start_ovf = ovf_cnt;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(byte_of(seed, i));
      rx_sof = (i == 0); rx_eof = (i == len - 1); rx_err = (i == err_pos);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    repeat (10) @(negedge clk);
    chk({tag, " write count"}, nlog - start_log, e_n);
    chk({"R9 ovf pulses ", tag}, ovf_cnt - start_ovf, exp_ovf);
    for (int j = 0; j < e_n && start_log + j < nlog; j++)
      chk({tag, " write"}, {log_a[start_log + j], log_d[start_log + j]},
          {14'(e_a[j]), 16'(e_d[j])});
    if (e_n > 0 && nlog > start_log) begin
      chk("R2 first write is marker clear",
          {log_a[start_log], log_d[start_log]}, {14'(hdr0 >> 1), 16'h0000});
      if (exp_ovf == 0)
        chk("R4 last write is done marker",
            {log_a[nlog - 1], log_d[nlog - 1]}, {14'(hdr0 >> 1), 16'h0008});
    end
  endtask

  task automatic t_reset();
    do_reset(1, 1, 0);
    repeat (5) @(negedge clk);
    chk("R1 no writes after reset", nlog, 0);
    chk("R1 ovf low after reset", int'(ovf), 0);
  endtask

  task automatic t_basic();
    run_frame(6, 'h11, -1, "R3 R5 R6 R7 even good");
    chk("R1 first header at lower page", int'(log_a[0]), 'h100 >> 1);
    run_frame(5, 'h40, 2, "R3 R5 odd with error");
    run_frame(1, 'hA5, -1, "R3 R6 single byte");
  endtask

  task automatic t_wrap();
    run_frame(100, 'h03, -1, "R7 long");
    run_frame(100, 'h77, -1, "R8 header across wrap");
    run_frame(100, 'h5C, -1, "R8 payload after wrap");
  endtask

  task automatic t_stop();
    int h, s;
    h = m_hdr;
    s = h; for (int k = 0; k < 10; k++) s = nx(s);
    stop_word = 14'(s >> 1);
    run_frame(40, 'h21, -1, "R9 drop in payload");
    chk("R9 header kept after payload drop", m_hdr, h);
    s = nx(nx(h));
    stop_word = 14'(s >> 1);
    run_frame(10, 'h31, -1, "R9 drop at header slot");
    s = h; for (int k = 0; k < 9; k++) s = nx(s);
    stop_word = 14'(s >> 1);
    run_frame(10, 'h52, -1, "R9 frame ends at stop");
    chk("R7 next header equals stop", m_hdr, s);
    run_frame(4, 'h63, -1, "R9 ring full");
    stop_word = '0;
    run_frame(4, 'h64, -1, "R9 reuse after release");
    chk("R9 no write to stop word", stop_hits, 0);
    chk("R10 all writes inside area", out_region, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_stop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule